// File: doc/BRIEF.md
# Endian-Selectable Pixel Unpacker and Colour Mapper

This block sits between a display frame buffer fetch path and a parallel active-matrix panel bus. It accepts 32-bit words from frame memory and turns each one into a sequence of pixels. The pixel depth is 4, 8 or 16 bits. A single order bit chooses whether the pixels in a word are taken from the least significant end or from the most significant end.

In the two indexed depths, each pixel selects one entry of an on-block colour table. The table has 256 entries of 12 bits each, and software loads it through a write port. The 12-bit colour drives the low twelve lines of a 16-line output bus, and the upper four lines are released. In the 16-bit depth, the pixel goes to all sixteen lines unchanged. Software decides how those bits split into red, green and blue. Every output line has its own enable bit.

Both sides of the block use a valid/ready handshake, with one word in and one pixel out per transfer. The depth and the order are sampled together with each word.

Top module: `pix_unpack_map`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `out_valid` at 0, `out_oe` at 0 and `in_ready` at 1. Any word that was only partly emitted is discarded.
- R2: `cfg_depth` selects 4 bpp when it is 0, 8 bpp when it is 1, and 16 bpp when it is 2 or 3. A word gives 8, 4 or 2 pixels in those modes. `in_ready` stays 0 from the edge that accepts a word until its last pixel has been issued, and no extra beats appear.
- R3: With `cfg_big` at 0, the first pixel of a word is taken from bit 0 upward. For example, at 4 bpp the pixels come out in the order bits 3:0, 7:4, up to 31:28.
- R4: With `cfg_big` at 1, the first pixel is taken from the top of the word: bits 31:28, 31:24 or 31:16. Each later pixel is the next lower field.
- R5: At 16 bpp, `out_data` equals the pixel bits unchanged and `out_oe` is 16'hFFFF.
- R6: At 4 and 8 bpp, `out_data[11:0]` is the addressed colour entry (red in 11:8, green in 7:4, blue in 3:0). `out_data[15:12]` is 0 and `out_oe` is 16'h0FFF.
- R7: At 4 bpp, a pixel value n addresses entry n. Entries 16 to 255 are never selected.
- R8: When `pal_we` is high at a clock edge, `pal_wdata` is stored at `pal_addr`. Pixels issued after that edge use the new colour.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_oe` stay unchanged.
- R10: Depth and order are sampled only when a word is accepted. Changing `cfg_depth` or `cfg_big` in the middle of a word does not change the rest of that word's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_depth | input | 2 | Pixel depth select, sampled with each word |
| cfg_big | input | 1 | 1 = take pixels from the high end first |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be accepted |
| in_word | input | 32 | Frame buffer word |
| pal_we | input | 1 | Colour table write strobe |
| pal_addr | input | 8 | Colour table write address |
| pal_wdata | input | 12 | Colour table write data |
| out_valid | output | 1 | Pixel beat valid |
| out_ready | input | 1 | Sink accepts the beat |
| out_data | output | 16 | Panel data lines |
| out_oe | output | 16 | Per-line output enable |

## Verification
The bench walks words through every combination of depth and order and compares each beat against a model built from field positions. A design that reverses the order, or takes the wrong field width, produces mismatched beats. Random backpressure and a long stall check that the beat on the bus holds still and that the colour read is not repeated or skipped; a design with a free-running table read would change the data while it is stalled. The bench flips depth and order in the middle of a word, which catches a design that decodes the live configuration. It also applies reset halfway through a word, which catches a design that leaks stale pixels afterwards. It rewrites a table entry and loads distinct colours into entries 16 and above, so 4-bpp indexing that is not zero-extended shows up.

// File: rtl/pum_pkg.sv
package pum_pkg;
    localparam int WORD_W  = 32;
    localparam int OUT_W   = 16;
    localparam int COLOR_W = 12;
    localparam int PAL_N   = 256;
    localparam int PAL_AW  = $clog2(PAL_N);
    localparam int CNT_W   = $clog2(WORD_W / 4 + 1);

    typedef enum logic [1:0] {
        DEPTH4  = 2'd0,
        DEPTH8  = 2'd1,
        DEPTH16 = 2'd2
    } depth_e;

    function automatic depth_e norm_depth(input logic [1:0] sel);
        case (sel)
            2'd0:    return DEPTH4;
            2'd1:    return DEPTH8;
            default: return DEPTH16;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] pix_per_word(input depth_e d);
        case (d)
            DEPTH4:  return CNT_W'(WORD_W / 4);
            DEPTH8:  return CNT_W'(WORD_W / 8);
            default: return CNT_W'(WORD_W / 16);
        endcase
    endfunction
endpackage

// File: rtl/pum_unpack.sv
module pum_unpack
    import pum_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic [1:0]        cfg_depth,
    input  logic              cfg_big,
    input  logic              take,
    output logic              pix_valid,
    output logic [OUT_W-1:0]  pix,
    output depth_e            pix_depth
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
        depth_e            depth;
        logic              big;
        logic              full;
    } unpack_t;

    unpack_t s_d, s_q;

    assign in_ready  = !s_q.full;
    assign pix_valid = s_q.full;
    assign pix_depth = s_q.depth;

    // current field at the head of the word
    always_comb begin
        case (s_q.depth)
            DEPTH4:  pix = s_q.big ? OUT_W'(s_q.word[WORD_W-1 -: 4])
                                   : OUT_W'(s_q.word[3:0]);
            DEPTH8:  pix = s_q.big ? OUT_W'(s_q.word[WORD_W-1 -: 8])
                                   : OUT_W'(s_q.word[7:0]);
            default: pix = s_q.big ? s_q.word[WORD_W-1 -: OUT_W]
                                   : s_q.word[OUT_W-1:0];
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (in_valid && in_ready) begin
            s_d.word  = in_word;
            s_d.depth = norm_depth(cfg_depth);
            s_d.big   = cfg_big;
            s_d.cnt   = pix_per_word(norm_depth(cfg_depth));
            s_d.full  = 1'b1;
        end else if (take && s_q.full) begin
            case (s_q.depth)
                DEPTH4:  s_d.word = s_q.big ? (s_q.word << 4) : (s_q.word >> 4);
                DEPTH8:  s_d.word = s_q.big ? (s_q.word << 8) : (s_q.word >> 8);
                default: s_d.word = s_q.big ? (s_q.word << OUT_W) : (s_q.word >> OUT_W);
            endcase
            s_d.cnt = s_q.cnt - {{(CNT_W-1){1'b0}}, 1'b1};
            if (s_q.cnt == {{(CNT_W-1){1'b0}}, 1'b1})
                s_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/pum_palette.sv
module pum_palette
    import pum_pkg::*;
(
    input  logic               clk,
    input  logic               we,
    input  logic [PAL_AW-1:0]  waddr,
    input  logic [COLOR_W-1:0] wdata,
    input  logic               re,
    input  logic [PAL_AW-1:0]  raddr,
    output logic [COLOR_W-1:0] rdata
);
    logic [COLOR_W-1:0] mem [PAL_N];
    logic [COLOR_W-1:0] rdata_q;

    assign rdata = rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata_q <= mem[raddr];
    end
endmodule

// File: rtl/pum_outstage.sv
module pum_outstage
    import pum_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_valid,
    input  logic [OUT_W-1:0]   pix,
    input  logic               pix_wide,
    input  logic [COLOR_W-1:0] pal_rdata,
    output logic               take,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OUT_W-1:0]   out_data,
    output logic [OUT_W-1:0]   out_oe
);
    typedef struct packed {
        logic             valid;
        logic             wide;
        logic [OUT_W-1:0] pass;
    } stage_t;

    stage_t s_d, s_q;
    logic   advance;

    assign advance = !s_q.valid || out_ready;
    assign take    = pix_valid && advance;

    always_comb begin
        s_d = s_q;
        if (advance) begin
            s_d.valid = pix_valid;
            if (pix_valid) begin
                s_d.wide = pix_wide;
                s_d.pass = pix;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        out_valid = s_q.valid;
        if (!s_q.valid) begin
            out_data = '0;
            out_oe   = '0;
        end else if (s_q.wide) begin
            out_data = s_q.pass;
            out_oe   = '1;
        end else begin
            out_data = OUT_W'(pal_rdata);
            out_oe   = OUT_W'({COLOR_W{1'b1}});
        end
    end
endmodule

// File: rtl/pix_unpack_map.sv
module pix_unpack_map
    import pum_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cfg_depth,
    input  logic               cfg_big,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    input  logic               pal_we,
    input  logic [PAL_AW-1:0]  pal_addr,
    input  logic [COLOR_W-1:0] pal_wdata,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OUT_W-1:0]   out_data,
    output logic [OUT_W-1:0]   out_oe
);
    logic               pix_valid;
    logic [OUT_W-1:0]   pix;
    depth_e             pix_depth;
    logic               take;
    logic [PAL_AW-1:0]  pal_idx;
    logic [COLOR_W-1:0] pal_rdata;

    // 4 bpp reaches only the low 16 entries (zero-extended index)
    assign pal_idx = (pix_depth == DEPTH4) ? PAL_AW'(pix[3:0]) : pix[PAL_AW-1:0];

    pum_unpack u_unpack (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_word   (in_word),
        .cfg_depth (cfg_depth),
        .cfg_big   (cfg_big),
        .take      (take),
        .pix_valid (pix_valid),
        .pix       (pix),
        .pix_depth (pix_depth)
    );

    pum_palette u_pal (
        .clk   (clk),
        .we    (pal_we),
        .waddr (pal_addr),
        .wdata (pal_wdata),
        .re    (take),
        .raddr (pal_idx),
        .rdata (pal_rdata)
    );

    pum_outstage u_out (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix       (pix),
        .pix_wide  (pix_depth == DEPTH16),
        .pal_rdata (pal_rdata),
        .take      (take),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_oe    (out_oe)
    );
endmodule

// File: rtl/pum_checks.sv
module pum_checks
    import pum_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input logic [OUT_W-1:0] out_oe
);
    logic rst_seen;

    always_ff @(posedge clk) rst_seen <= rst;

    // R1: state right after a reset edge
    always_ff @(posedge clk) begin
        if (rst_seen === 1'b1 && !rst)
            p_reset_clear_r1: assert (!out_valid && in_ready && out_oe == '0);
    end

    p_idle_oe_r1: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_oe == '0);

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    p_lane_enable_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_oe == '1 ||
                       (out_oe == OUT_W'({COLOR_W{1'b1}}) && out_data[OUT_W-1:COLOR_W] == '0)));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_oe)));
endmodule

bind pix_unpack_map pum_checks u_chk (.*);

// File: tb/pix_unpack_map_tb.sv
`timescale 1ns/1ps
module pix_unpack_map_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_depth = 2'd0;
    logic        cfg_big = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        pal_we = 1'b0;
    logic [7:0]  pal_addr = '0;
    logic [11:0] pal_wdata = '0;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_data;
    logic [15:0] out_oe;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [11:0] shadow [256];
    logic [15:0] exp_data [512];
    logic [15:0] exp_oe [512];
    int          exp_req [512];
    int          wr_idx = 0;
    int          rd_idx = 0;

    logic bp_en = 1'b0;
    logic rdy_force = 1'b1;

    always #2.5 clk = ~clk;

    pix_unpack_map u_dut (
        .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .cfg_big(cfg_big),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_oe(out_oe)
    );

    // stimulus vectors: {depth, big, word}
    localparam logic [34:0] VEC [0:7] = '{
        {2'd0, 1'b0, 32'h7654_3210},
        {2'd0, 1'b1, 32'hFEDC_BA98},
        {2'd1, 1'b0, 32'h0F1E_2D3C},
        {2'd1, 1'b1, 32'hA5B4_C3D2},
        {2'd2, 1'b0, 32'h1234_ABCD},
        {2'd2, 1'b1, 32'h8001_FFFE},
        {2'd3, 1'b0, 32'hCAFE_F00D},
        {2'd0, 1'b1, 32'h0123_4567}
    };

    always @(negedge clk) begin
        cyc <= cyc + 1;
        out_ready <= bp_en ? ((cyc % 3) != 1) : rdy_force;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // beat monitor: sampled 1 ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (!rst && out_valid && out_ready) begin
            n_checks++;
            if (rd_idx >= wr_idx) begin
                n_fail++;
                $display("FAIL R2 unexpected beat: data %h oe %h, expected no beat",
                         out_data, out_oe);
            end else begin
                if (out_data !== exp_data[rd_idx] || out_oe !== exp_oe[rd_idx]) begin
                    n_fail++;
                    $display("FAIL R%0d beat %0d: data %h oe %h, expected data %h oe %h",
                             exp_req[rd_idx], rd_idx, out_data, out_oe,
                             exp_data[rd_idx], exp_oe[rd_idx]);
                end
                rd_idx++;
            end
        end
    end

    // expected beats from field positions (R3 low-first, R4 high-first, R5/R6/R7 mapping)
    task automatic push_word(input logic [1:0] d, input logic b, input logic [31:0] w);
        int width = (d == 2'd0) ? 4 : (d == 2'd1) ? 8 : 16;
        int n = 32 / width;
        for (int k = 0; k < n; k++) begin
            int slot = b ? (n - 1 - k) : k;
            logic [31:0] field = (w >> (slot * width)) & ((32'd1 << width) - 1);
            if (width == 16) begin
                exp_data[wr_idx] = field[15:0];
                exp_oe[wr_idx]   = 16'hFFFF;
                exp_req[wr_idx]  = 5;
            end else begin
                exp_data[wr_idx] = {4'h0, shadow[field[7:0]]};
                exp_oe[wr_idx]   = 16'h0FFF;
                exp_req[wr_idx]  = b ? 4 : 3;
                if (width == 4) exp_req[wr_idx] = 7;
            end
            wr_idx++;
        end
    endtask

    task automatic send(input logic [1:0] d, input logic b, input logic [31:0] w);
        bit done = 0;
        @(negedge clk);
        cfg_depth = d; cfg_big = b; in_word = w; in_valid = 1'b1;
        while (!done) begin
            #1;
            if (in_ready) begin
                push_word(d, b, w);
                done = 1;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic pal_write(input logic [7:0] a, input logic [11:0] v);
        @(negedge clk);
        pal_we = 1'b1; pal_addr = a; pal_wdata = v;
        @(negedge clk);
        pal_we = 1'b0;
        shadow[a] = v;
    endtask

    task automatic drain(input string tag);
        int t = 0;
        while ((rd_idx != wr_idx || out_valid) && t < 300) begin
            @(negedge clk);
            t++;
        end
        check(rd_idx == wr_idx, tag, 32'(rd_idx), 32'(wr_idx));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
        check(out_oe == 16'h0, "R1 out_oe after reset", 32'(out_oe), 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 1);

        // R8: load table, entries above 15 distinct so R7 misindexing shows
        for (int i = 0; i < 256; i++) pal_write(8'(i), 12'((i * 173 + 53) & 12'hFFF));

        // table walk: R2..R7
        for (int v = 0; v < 8; v++) send(VEC[v][34:33], VEC[v][32], VEC[v][31:0]);
        drain("R2 all table beats delivered");

        // R8: rewrite an entry then use it
        pal_write(8'h21, 12'hABC);
        send(2'd1, 1'b0, 32'h2121_2121);
        drain("R8 rewritten entry used");

        // R9 and R10: stall, flip config in the middle of a word
        rdy_force = 1'b0;
        @(negedge clk);
        send(2'd1, 1'b1, 32'h0403_0201);
        repeat (2) @(negedge clk);
        #1;
        check(out_valid == 1'b1, "R9 beat presented while stalled", 32'(out_valid), 1);
        check(in_ready == 1'b0, "R2 busy mid-word", 32'(in_ready), 0);
        held = out_data;
        check(out_data == exp_data[rd_idx], "R4 first stalled beat", 32'(out_data),
              32'(exp_data[rd_idx]));
        cfg_depth = 2'd2; cfg_big = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        check(out_valid == 1'b1 && out_data == held, "R9 data held under stall",
              32'(out_data), 32'(held));
        rdy_force = 1'b1;
        drain("R10 rest of word uses sampled config");

        // backpressure pattern: R9
        bp_en = 1'b1;
        send(2'd0, 1'b0, 32'h89AB_CDEF);
        send(2'd2, 1'b1, 32'h5A5A_0F0F);
        send(2'd1, 1'b1, 32'h1000_00FF);
        drain("R9 beats under backpressure");
        bp_en = 1'b0;

        // R1: reset in the middle of a word
        rdy_force = 1'b0;
        @(negedge clk);
        send(2'd0, 1'b0, 32'hDDDD_DDDD);
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(out_valid == 1'b0, "R1 out_valid after mid-word reset", 32'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready after mid-word reset", 32'(in_ready), 1);
        check(out_oe == 16'h0, "R1 out_oe after mid-word reset", 32'(out_oe), 0);
        rd_idx = wr_idx;
        rdy_force = 1'b1;
        send(2'd0, 1'b1, 32'h1234_5678);
        drain("R1 fresh word after reset");

        // R1 idle enables
        @(negedge clk);
        #1;
        check(out_oe == 16'h0 && !out_valid, "R1 idle enables released", 32'(out_oe), 0);

        finish_run();
    end
endmodule